// File: doc/BRIEF.md
# Auto-reload interval timer

This block is a 32-bit up-counting timer for periodic tick generation. Once started, the count rises by one on every tick. A tick is either every clock or, when the divider is on, one clock in every 2^(k+1), where k is a 3-bit code. When the count passes all ones it wraps to a programmed reload value, so software gets a tick period of 2^32 minus that value. For a period of N ticks, write 2^32 - N to both the reload and the count registers. A one-shot mode instead wraps to zero and halts the timer.

Three event sources set bits in one sticky status word: a compare hit, a wrap (overflow), and a pulse on the external capture input. Software clears status bits by writing ones to them. An interrupt handler therefore acknowledges by writing back the word it read, and reading zero means the interrupt was spurious. A per-source enable mask reduces the status word to a single interrupt line. A soft-reset command returns every register to its default within one cycle, and a done flag reports the end of that reset.

Registers are reached through a single-cycle write strobe with a word address. Reads are combinational on the address.

Top module: `reload_timer`

## Requirements
- R1: After reset, control, count, reload, compare, status and enable all read zero, `irq` is low, and the system word (address 0x7) reads 1 in bit 0 (reset finished).
- R2: While control bit 0 (run) is set, the count rises by exactly one per tick. While it is clear, the count holds.
- R3: Control bits 4:2 hold a divider code k, and control bit 5 enables the divider. With bit 5 set, a tick occurs once every 2^(k+1) clocks. With bit 5 clear, a tick occurs every clock.
- R4: A tick taken at all ones sets status bit 1 (wrap). If control bit 1 (reload) is set, the count then becomes the reload register (address 0x2), which gives a period of 2^32 minus the reload value.
- R5: With control bit 1 clear, a wrap loads zero into the count and clears the run bit.
- R6: With control bit 6 set, status bit 0 is set on the same edge at which the count takes the value of the compare register (address 0x4). With bit 6 clear, reaching that value leaves status bit 0 unchanged.
- R7: Any write to the trigger address (0x3) copies the reload register into the count on that edge, ahead of any tick.
- R8: A high level on `cap_event` during a clock sets status bit 2 on that edge.
- R9: Writing the status address (0x5) clears each bit written as 1 and leaves bits written as 0 unchanged. A source event in the same cycle as its clear wins.
- R10: `irq` is high exactly when some status bit and the matching enable bit (address 0x6, bits 2:0) are both set.
- R11: Writing 1 to bit 0 of the system word (0x7) starts a soft reset. For one cycle the system word reads 0, then all registers hold their defaults and it reads 1 again.
- R12: A write to the count address (0x1) loads the count directly and takes priority over a tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Word address: 0 control, 1 count, 2 reload, 3 trigger, 4 compare, 5 status, 6 enable, 7 system |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_event | input | 1 | Capture event from the neighbouring capture block |
| irq | output | 1 | Interrupt line |

## Verification
A table runs the counter with the divider off and with codes giving division by 2, 8 and 256. Sampling one clock before and at the third increment separates a correct 2^(k+1) ratio from an off-by-one exponent. Wrap tests use a five-tick reload period and a one-shot run, which tell the reload path apart from the zero-and-halt path and show when the wrap flag appears. Compare with its enable on and off, a trigger and a count write made while ticking, and a capture pulse raised in the same cycle as its clear probe the priority between software writes and hardware events.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int PTV_W     = 3;
    localparam int PRE_CNT_W = 1 << PTV_W;
    localparam int NUM_SRC   = 3;

    localparam int SRC_MATCH = 0;
    localparam int SRC_WRAP  = 1;
    localparam int SRC_CAP   = 2;

    typedef struct packed {
        logic             cmp_en;
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
        logic             autoreload;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 4'h0,
        REG_COUNT  = 4'h1,
        REG_LOAD   = 4'h2,
        REG_TRIG   = 4'h3,
        REG_MATCH  = 4'h4,
        REG_STATUS = 4'h5,
        REG_ENABLE = 4'h6,
        REG_SYSCFG = 4'h7
    } reg_addr_e;

    localparam logic [PRE_CNT_W:0] PRE_ONE = 1;

    function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PTV_W-1:0] ptv);
        logic [PTV_W:0]     sh;
        logic [PRE_CNT_W:0] full;
        sh   = {1'b0, ptv} + 1'b1;
        full = (PRE_ONE << sh) - PRE_ONE;
        return full[PRE_CNT_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] zext_src(input logic [NUM_SRC-1:0] v);
        return {{(DATA_W-NUM_SRC){1'b0}}, v};
    endfunction

endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
    import reload_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);

    logic [PRE_CNT_W-1:0] cnt_q;
    logic [PRE_CNT_W-1:0] limit;
    logic                 at_limit;

    assign limit    = pre_limit(ptv);
    assign at_limit = (cnt_q >= limit);
    assign tick     = run && (!pre_en || at_limit);

    always_ff @(posedge clk) begin
        if (rst || !run || !pre_en) begin
            cnt_q <= '0;
        end else if (at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rt_counter.sv
module rt_counter
    import reload_timer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         autoreload,
    input  logic         cmp_en,
    input  logic         wr_count,
    input  logic         trig,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] count,
    output logic         wrap_ev,
    output logic         match_ev
);

    logic [W-1:0] count_q;
    logic [W-1:0] step_val;
    logic         at_top;
    logic         sw_load;

    assign sw_load = wr_count || trig;
    assign at_top  = &count_q;

    always_comb begin
        if (at_top) begin
            step_val = autoreload ? load_val : '0;
        end else begin
            step_val = count_q + 1'b1;
        end
    end

    assign wrap_ev  = tick && at_top && !sw_load;
    assign match_ev = tick && cmp_en && !sw_load && (step_val == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= wr_data;
        end else if (trig) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= step_val;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/rt_irq_status.sv
module rt_irq_status
    import reload_timer_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [N-1:0] en_data,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq
);

    logic [N-1:0] enable_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_ev[i]) begin
                bit_q <= 1'b1;
            end else if (clr_wr && clr_mask[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign status[i] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= en_data;
        end
    end

    assign enable = enable_q;
    assign irq    = |(status & enable_q);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import reload_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cap_event,
    output logic              irq
);

    logic               srst_pend;
    logic               rst_i;
    ctrl_t              ctrl_q;
    logic [DATA_W-1:0]  load_q;
    logic [DATA_W-1:0]  match_q;
    logic [DATA_W-1:0]  count;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] set_ev;
    logic               cnt_tick;
    logic               wrap_ev;
    logic               match_ev;
    logic               wr_ok;
    logic               wr_ctrl;
    logic               wr_count;
    logic               wr_load;
    logic               trig;
    logic               wr_match;
    logic               wr_status;
    logic               wr_enable;
    logic               wr_sys;

    assign rst_i = rst || srst_pend;
    assign wr_ok = reg_wr && !srst_pend;

    always_comb begin
        wr_ctrl   = 1'b0;
        wr_count  = 1'b0;
        wr_load   = 1'b0;
        trig      = 1'b0;
        wr_match  = 1'b0;
        wr_status = 1'b0;
        wr_enable = 1'b0;
        wr_sys    = 1'b0;
        if (wr_ok) begin
            case (reg_addr)
                REG_CTRL:   wr_ctrl   = 1'b1;
                REG_COUNT:  wr_count  = 1'b1;
                REG_LOAD:   wr_load   = 1'b1;
                REG_TRIG:   trig      = 1'b1;
                REG_MATCH:  wr_match  = 1'b1;
                REG_STATUS: wr_status = 1'b1;
                REG_ENABLE: wr_enable = 1'b1;
                REG_SYSCFG: wr_sys    = 1'b1;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_pend <= 1'b0;
        end else begin
            srst_pend <= wr_sys && reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end else if (wrap_ev && !ctrl_q.autoreload) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            load_q  <= '0;
            match_q <= '0;
        end else begin
            if (wr_load) begin
                load_q <= reg_wdata;
            end
            if (wr_match) begin
                match_q <= reg_wdata;
            end
        end
    end

    rt_prescaler u_pre (
        .clk    (clk),
        .rst    (rst_i),
        .run    (ctrl_q.run),
        .pre_en (ctrl_q.pre_en),
        .ptv    (ctrl_q.ptv),
        .tick   (cnt_tick)
    );

    rt_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst        (rst_i),
        .tick       (cnt_tick),
        .autoreload (ctrl_q.autoreload),
        .cmp_en     (ctrl_q.cmp_en),
        .wr_count   (wr_count),
        .trig       (trig),
        .wr_data    (reg_wdata),
        .load_val   (load_q),
        .match_val  (match_q),
        .count      (count),
        .wrap_ev    (wrap_ev),
        .match_ev   (match_ev)
    );

    always_comb begin
        set_ev            = '0;
        set_ev[SRC_MATCH] = match_ev;
        set_ev[SRC_WRAP]  = wrap_ev;
        set_ev[SRC_CAP]   = cap_event;
    end

    rt_irq_status #(.N(NUM_SRC)) u_irq (
        .clk      (clk),
        .rst      (rst_i),
        .set_ev   (set_ev),
        .clr_wr   (wr_status),
        .clr_mask (reg_wdata[NUM_SRC-1:0]),
        .en_wr    (wr_enable),
        .en_data  (reg_wdata[NUM_SRC-1:0]),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr)
            REG_CTRL:   reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            REG_COUNT:  reg_rdata = count;
            REG_LOAD:   reg_rdata = load_q;
            REG_MATCH:  reg_rdata = match_q;
            REG_STATUS: reg_rdata = zext_src(status);
            REG_ENABLE: reg_rdata = zext_src(enable);
            REG_SYSCFG: reg_rdata = {{(DATA_W-1){1'b0}}, !srst_pend};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
    import reload_timer_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               srst_pend,
    input ctrl_t              ctrl_q,
    input logic [DATA_W-1:0]  count,
    input logic [DATA_W-1:0]  load_q,
    input logic [NUM_SRC-1:0] status,
    input logic               wrap_ev,
    input logic               cnt_tick,
    input logic               wr_ctrl,
    input logic               wr_count,
    input logic               trig,
    input logic               wr_status
);

    // R2: with no tick and no software load, the count holds
    a_r2_count_holds: assert property (@(posedge clk) disable iff (rst || srst_pend)
        (!cnt_tick && !wr_count && !trig) |=> (count == $past(count)));

    // R4: a wrap in reload mode leaves the reload value in the count
    a_r4_wrap_reloads: assert property (@(posedge clk) disable iff (rst || srst_pend)
        (wrap_ev && ctrl_q.autoreload) |=> (count == $past(load_q)));

    // R5: a wrap in one-shot mode halts the timer
    a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (rst || srst_pend)
        (wrap_ev && !ctrl_q.autoreload && !wr_ctrl) |=> (!ctrl_q.run && count == '0));

    // R9: status bits only drop on a status write
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (rst || srst_pend)
        !wr_status |=> ((status & $past(status)) == $past(status)));

    // R11: soft reset lasts one cycle and leaves defaults behind
    a_r11_soft_defaults: assert property (@(posedge clk) disable iff (rst)
        srst_pend |=> (!srst_pend && ctrl_q == '0 && count == '0 && status == '0));

endmodule

bind reload_timer reload_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .srst_pend (srst_pend),
    .ctrl_q    (ctrl_q),
    .count     (count),
    .load_q    (load_q),
    .status    (status),
    .wrap_ev   (wrap_ev),
    .cnt_tick  (cnt_tick),
    .wr_ctrl   (wr_ctrl),
    .wr_count  (wr_count),
    .trig      (trig),
    .wr_status (wr_status)
);

// File: tb/reload_timer_tb.sv
`timescale 1ns/100ps
module reload_timer_tb;

    localparam logic [3:0] A_CTRL = 4'h0, A_COUNT = 4'h1, A_LOAD = 4'h2, A_TRIG = 4'h3,
                           A_MATCH = 4'h4, A_STATUS = 4'h5, A_ENABLE = 4'h6, A_SYS = 4'h7;

    // prescaler table: [19] divider enable, [18:16] code, [15:0] clocks per increment
    localparam logic [19:0] PRE_VEC [4] = '{
        {1'b0, 3'd5, 16'd1},
        {1'b1, 3'd0, 16'd2},
        {1'b1, 3'd2, 16'd8},
        {1'b1, 3'd7, 16'd256}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_event = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    reload_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_event (cap_event),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
        rd(A_COUNT, v);  chk("R1 count", v, 32'h0);
        rd(A_STATUS, v); chk("R1 status", v, 32'h0);
        rd(A_SYS, v);    chk("R1 reset done", v, 32'h1);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 / R2 prescaler table
        for (int i = 0; i < 4; i++) begin
            int div;
            div = int'(PRE_VEC[i][15:0]);
            wr(A_CTRL, 32'h0);
            wr(A_COUNT, 32'h0);
            wr(A_CTRL, {26'b0, PRE_VEC[i][19], PRE_VEC[i][18:16], 1'b0, 1'b1});
            idle(3 * div - 1);
            rd(A_COUNT, v); chk("R3 count before third step", v, 32'd2);
            idle(1);
            rd(A_COUNT, v); chk("R3 count at third step", v, 32'd3);
            wr(A_CTRL, 32'h0);
            rd(A_COUNT, held);
            idle(5);
            rd(A_COUNT, v); chk("R2 count holds when stopped", v, held);
        end

        // R4 reload period of 5 ticks
        wr(A_LOAD, 32'hFFFF_FFFB);
        wr(A_COUNT, 32'hFFFF_FFFB);
        wr(A_CTRL, 32'h3);
        idle(4);
        rd(A_COUNT, v);  chk("R4 count at top", v, 32'hFFFF_FFFF);
        rd(A_STATUS, v); chk("R4 no wrap yet", v, 32'h0);
        idle(1);
        rd(A_STATUS, v); chk("R4 wrap flag", v, 32'h2);
        rd(A_COUNT, v);  chk("R4 reloaded", v, 32'hFFFF_FFFB);
        wr(A_STATUS, 32'h2);
        rd(A_STATUS, v); chk("R9 clear by one", v, 32'h0);
        idle(3);
        rd(A_STATUS, v); chk("R4 second period not yet", v, 32'h0);
        idle(1);
        rd(A_STATUS, v); chk("R4 second wrap", v, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_STATUS, 32'h5);
        rd(A_STATUS, v); chk("R9 zero bits leave status", v, 32'h2);

        // R10 masking
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        wr(A_ENABLE, 32'h2);
        chk("R10 irq enabled", {31'b0, irq}, 32'h1);
        wr(A_ENABLE, 32'h1);
        chk("R10 other enable", {31'b0, irq}, 32'h0);
        wr(A_ENABLE, 32'h2);
        wr(A_STATUS, 32'h2);
        chk("R10 irq drops on clear", {31'b0, irq}, 32'h0);

        // R5 one-shot
        wr(A_LOAD, 32'h55);
        wr(A_COUNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h1);
        idle(2);
        rd(A_COUNT, v);  chk("R5 count zero after wrap", v, 32'h0);
        rd(A_CTRL, v);   chk("R5 run cleared", v, 32'h0);
        rd(A_STATUS, v); chk("R5 wrap flag", v, 32'h2);
        idle(4);
        rd(A_COUNT, v);  chk("R5 stays halted", v, 32'h0);
        wr(A_STATUS, 32'h7);

        // R6 compare
        wr(A_MATCH, 32'd10);
        wr(A_COUNT, 32'd7);
        wr(A_CTRL, 32'h41);
        idle(2);
        rd(A_STATUS, v); chk("R6 no match at 9", v, 32'h0);
        idle(1);
        rd(A_STATUS, v); chk("R6 match at 10", v, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_STATUS, 32'h7);
        wr(A_COUNT, 32'd7);
        wr(A_CTRL, 32'h1);
        idle(5);
        wr(A_CTRL, 32'h0);
        rd(A_STATUS, v); chk("R6 compare disabled", v, 32'h0);
        rd(A_COUNT, v);  chk("R2 one per tick", v, 32'd13);

        // R7 trigger
        wr(A_LOAD, 32'd100);
        wr(A_COUNT, 32'd5);
        wr(A_CTRL, 32'h1);
        idle(2);
        rd(A_COUNT, v);  chk("R2 running", v, 32'd7);
        wr(A_TRIG, 32'h0);
        rd(A_COUNT, v);  chk("R7 trigger reload", v, 32'd100);
        idle(1);
        rd(A_COUNT, v);  chk("R7 counts on", v, 32'd101);

        // R12 count write beats tick
        wr(A_COUNT, 32'd50);
        rd(A_COUNT, v);  chk("R12 direct load", v, 32'd50);
        wr(A_CTRL, 32'h0);

        // R8 capture, R9 set wins
        wr(A_ENABLE, 32'h4);
        cap_event = 1'b1;
        idle(1);
        cap_event = 1'b0;
        rd(A_STATUS, v); chk("R8 capture flag", v, 32'h4);
        chk("R10 capture irq", {31'b0, irq}, 32'h1);
        cap_event = 1'b1;
        wr(A_STATUS, 32'h4);
        cap_event = 1'b0;
        rd(A_STATUS, v); chk("R9 set beats clear", v, 32'h4);
        wr(A_STATUS, 32'h4);
        rd(A_STATUS, v); chk("R9 cleared", v, 32'h0);

        // R11 soft reset
        wr(A_LOAD, 32'h1234);
        wr(A_CTRL, 32'h22);
        wr(A_ENABLE, 32'h7);
        cap_event = 1'b1;
        idle(1);
        cap_event = 1'b0;
        wr(A_SYS, 32'h1);
        rd(A_SYS, v);    chk("R11 reset in progress", v, 32'h0);
        idle(1);
        rd(A_SYS, v);    chk("R11 reset done", v, 32'h1);
        rd(A_CTRL, v);   chk("R11 ctrl default", v, 32'h0);
        rd(A_LOAD, v);   chk("R11 reload default", v, 32'h0);
        rd(A_STATUS, v); chk("R11 status default", v, 32'h0);
        rd(A_ENABLE, v); chk("R11 enable default", v, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule